// File: doc/BRIEF.md
# Frame and Multiframe Sync Generator

This block divides the main equipment clock down to two square-wave timing references: a frame sync wave (8 kHz when the source clock is 19.44 MHz) and a multiframe sync wave at a quarter of that rate (2 kHz). Both waves have an exact 50:50 mark-space ratio. They are decoded from a single position counter, so their phase relationship is fixed. The block runs on the system clock and advances only on cycles where `tick_en` is high. This lets a caller feed it either the source clock directly, with `tick_en` tied high, or a faster clock together with an enable at the source rate.

In a redundant pair, the standby unit is put in slave mode and its `partner_mf_in` input is fed from the multiframe output of the active unit. A rising edge on that input passes through a synchronizer and then restarts the position counter at frame 0, cycle 0, on the next tick. The two units then emit phase-aligned sync waves, and a protection switch causes no phase step. If the partner edge lands when the counter is already at the start of frame 0, nothing is changed, so no pulse is shortened or duplicated. Two one-cycle strobes mark frame and multiframe boundaries for local logic.

Top module: `sync_wave_gen`

## Requirements
- R1: `frame_sync_o` is high for FRAME_CYCLES/2 ticks, then low for FRAME_CYCLES/2 ticks, and repeats with a period of FRAME_CYCLES ticks. With the default of 2430, it is high for 1215 ticks and low for 1215 ticks.
- R2: `mframe_sync_o` is high during frames 0 and 1 and low during frames 2 and 3 of each FRAMES_PER_MF = 4 frame multiframe. When running freely, it changes only on the tick where `frame_sync_o` rises. Both waves rise on the same edge at the start of frame 0.
- R3: On a cycle where `tick_en` is low, the position does not move, and neither sync output changes on the following edge.
- R4: `frame_strobe_o` is high for exactly one cycle at each frame boundary. It is asserted in the cycle where `tick_en` is high and the position is cycle 0 of a frame.
- R5: `mframe_strobe_o` is high only in the cycle where `tick_en` is high and the position is cycle 0 of frame 0. It is therefore always a subset of `frame_strobe_o`.
- R6: With `slave_mode` high, a 0-to-1 change on `partner_mf_in` is detected through a SYNC_STAGES-flop synchronizer (default 2). The first tick at or after detection loads the position to frame 0, cycle 0. With `tick_en` high throughout, this happens on the third rising clock edge after the input rises. A detection on a cycle without a tick is held until the next tick.
- R7: With `slave_mode` low, `partner_mf_in` has no effect on any output.
- R8: If the load of R6 falls due while the position is already frame 0, cycle 0, the counter advances normally instead. The high phase is then neither shortened nor restarted.
- R9: A synchronous active-low reset puts the position at frame 0, cycle 0. Both sync outputs are then high, and the strobes follow `tick_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Source-rate enable; the position advances on each cycle where it is high |
| slave_mode | input | 1 | 1 = follow the partner's multiframe wave, 0 = free-running master |
| partner_mf_in | input | 1 | Multiframe sync wave from the partner unit (asynchronous) |
| frame_sync_o | output | 1 | Frame sync square wave |
| mframe_sync_o | output | 1 | Multiframe sync square wave |
| frame_strobe_o | output | 1 | One-cycle pulse at each frame start |
| mframe_strobe_o | output | 1 | One-cycle pulse at each multiframe start |

## Verification
A corrupted cycle count makes the frame wave's next edge come early or late. With the short bench frame, the error is visible within one frame period. A wrong frame index leaves the frame wave intact, but shows up on the multiframe wave and its strobe within one multiframe. Faults in the partner path appear only after a partner edge: either the third edge after it, or the first tick after a held detection. If the realign is missing, skipped or spurious, the wave phase is wrong from that tick on, so every later compare also fails.

// File: rtl/sync_wave_pkg.sv
package sync_wave_pkg;
  localparam int unsigned DEF_FRAME_CYCLES = 2430;
  localparam int unsigned DEF_FRAMES_PER_MF = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/partner_align.sv
module partner_align #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic slave_mode,
  input  logic partner_in,
  output logic align_req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   held_q;
  logic                   rise;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= partner_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rise = slave_mode & sync_q[SYNC_STAGES-1] & ~last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      last_q <= sync_q[SYNC_STAGES-1];
      if (tick_en)   held_q <= 1'b0;
      else if (rise) held_q <= 1'b1;
    end
  end

  assign align_req = rise | held_q;
endmodule

// File: rtl/position_counter.sv
module position_counter #(
  parameter int unsigned FRAME_CYCLES  = 2430,
  parameter int unsigned FRAMES_PER_MF = 4,
  localparam int unsigned CW = sync_wave_pkg::width_of(FRAME_CYCLES),
  localparam int unsigned FW = sync_wave_pkg::width_of(FRAMES_PER_MF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          align_req,
  output logic [CW-1:0] cyc_q,
  output logic [FW-1:0] frm_q
);
  localparam logic [CW-1:0] CYC_LAST = CW'(FRAME_CYCLES - 1);
  localparam logic [FW-1:0] FRM_LAST = FW'(FRAMES_PER_MF - 1);

  logic at_start;
  logic cyc_wrap;

  assign at_start = (cyc_q == '0) && (frm_q == '0);
  assign cyc_wrap = (cyc_q == CYC_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      frm_q <= '0;
    end else if (tick_en) begin
      if (align_req && !at_start) begin
        cyc_q <= '0;
        frm_q <= '0;
      end else if (cyc_wrap) begin
        cyc_q <= '0;
        frm_q <= (frm_q == FRM_LAST) ? '0 : frm_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wave_decode.sv
module wave_decode #(
  parameter int unsigned FRAME_CYCLES  = 2430,
  parameter int unsigned FRAMES_PER_MF = 4,
  localparam int unsigned CW = sync_wave_pkg::width_of(FRAME_CYCLES),
  localparam int unsigned FW = sync_wave_pkg::width_of(FRAMES_PER_MF)
) (
  input  logic          tick_en,
  input  logic [CW-1:0] cyc_q,
  input  logic [FW-1:0] frm_q,
  output logic          frame_sync,
  output logic          mframe_sync,
  output logic          frame_strobe,
  output logic          mframe_strobe
);
  localparam logic [CW-1:0] CYC_HALF = CW'(FRAME_CYCLES / 2);
  localparam logic [FW-1:0] FRM_HALF = FW'(FRAMES_PER_MF / 2);

  always_comb begin
    frame_sync    = (cyc_q < CYC_HALF);
    mframe_sync   = (frm_q < FRM_HALF);
    frame_strobe  = tick_en && (cyc_q == '0);
    mframe_strobe = frame_strobe && (frm_q == '0);
  end
endmodule

// File: rtl/sync_wave_gen.sv
module sync_wave_gen #(
  parameter int unsigned FRAME_CYCLES  = sync_wave_pkg::DEF_FRAME_CYCLES,
  parameter int unsigned FRAMES_PER_MF = sync_wave_pkg::DEF_FRAMES_PER_MF,
  parameter int unsigned SYNC_STAGES   = sync_wave_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic slave_mode,
  input  logic partner_mf_in,
  output logic frame_sync_o,
  output logic mframe_sync_o,
  output logic frame_strobe_o,
  output logic mframe_strobe_o
);
  localparam int unsigned CW = sync_wave_pkg::width_of(FRAME_CYCLES);
  localparam int unsigned FW = sync_wave_pkg::width_of(FRAMES_PER_MF);

  logic          align_req;
  logic [CW-1:0] cyc_q;
  logic [FW-1:0] frm_q;

  partner_align #(.SYNC_STAGES(SYNC_STAGES)) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .slave_mode (slave_mode),
    .partner_in (partner_mf_in),
    .align_req  (align_req)
  );

  position_counter #(
    .FRAME_CYCLES  (FRAME_CYCLES),
    .FRAMES_PER_MF (FRAMES_PER_MF)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .align_req (align_req),
    .cyc_q     (cyc_q),
    .frm_q     (frm_q)
  );

  wave_decode #(
    .FRAME_CYCLES  (FRAME_CYCLES),
    .FRAMES_PER_MF (FRAMES_PER_MF)
  ) u_dec (
    .tick_en       (tick_en),
    .cyc_q         (cyc_q),
    .frm_q         (frm_q),
    .frame_sync    (frame_sync_o),
    .mframe_sync   (mframe_sync_o),
    .frame_strobe  (frame_strobe_o),
    .mframe_strobe (mframe_strobe_o)
  );
endmodule

// File: rtl/sync_wave_checker.sv
module sync_wave_checker (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic slave_mode,
  input logic frame_sync_o,
  input logic mframe_sync_o,
  input logic frame_strobe_o,
  input logic mframe_strobe_o
);
  // R3: no tick, no movement of either wave
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(frame_sync_o) && $stable(mframe_sync_o)));

  // R2: free-running multiframe edges coincide with a frame rising edge
  a_r2_mf_on_frame_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !$stable(mframe_sync_o)) |-> $rose(frame_sync_o));

  // R4: frame strobe only in a ticking cycle of the high phase
  a_r4_strobe_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe_o |-> (tick_en && frame_sync_o));

  // R5: multiframe strobe nested in frame strobe, during multiframe high
  a_r5_mf_strobe_nested: assert property (@(posedge clk) disable iff (!rst_n)
    mframe_strobe_o |-> (frame_strobe_o && mframe_sync_o));

  // R4: a frame strobe marks a position, so the next tick moves off it
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe_o && !slave_mode) |=> !frame_strobe_o);
endmodule

bind sync_wave_gen sync_wave_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tick_en         (tick_en),
  .slave_mode      (slave_mode),
  .frame_sync_o    (frame_sync_o),
  .mframe_sync_o   (mframe_sync_o),
  .frame_strobe_o  (frame_strobe_o),
  .mframe_strobe_o (mframe_strobe_o)
);

// File: tb/sync_wave_gen_test.sv
`timescale 1ns/1ps
module sync_wave_gen_test;
  localparam int FC = 10;
  localparam int NF = 4;
  localparam int PER = FC * NF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic slave_mode = 1'b0;
  logic partner_mf_in = 1'b0;
  logic frame_sync_o, mframe_sync_o, frame_strobe_o, mframe_strobe_o;

  int n_checks = 0;
  int n_fails = 0;
  bit chk_en = 1'b0;
  string tag = "R9";

  int pos = 0;
  bit p1 = 0, p2 = 0, p3 = 0, pend = 0;

  always #2.5 clk = ~clk;

  sync_wave_gen #(.FRAME_CYCLES(FC), .FRAMES_PER_MF(NF), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .slave_mode(slave_mode),
    .partner_mf_in(partner_mf_in), .frame_sync_o(frame_sync_o),
    .mframe_sync_o(mframe_sync_o), .frame_strobe_o(frame_strobe_o),
    .mframe_strobe_o(mframe_strobe_o)
  );

  // Arithmetic reference: position in ticks since the multiframe start
  always @(posedge clk) begin
    bit rise;
    if (!rst_n) begin
      pos = 0; p1 = 0; p2 = 0; p3 = 0; pend = 0;
    end else begin
      rise = slave_mode && p2 && !p3;
      if (tick_en) begin
        if ((rise || pend) && pos != 0) pos = 0;
        else pos = (pos + 1) % PER;
        pend = 0;
      end else if (rise) pend = 1;
      p3 = p2; p2 = p1; p1 = partner_mf_in;
    end
  end

  task automatic cmp(input string what, input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s (%s) %s: actual %b expected %b at pos %0d, t=%0t",
               req, tag, what, act, exp, pos, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      cmp("frame_sync", "R1", frame_sync_o, (pos % FC) < FC / 2);
      cmp("mframe_sync", "R2", mframe_sync_o, (pos / FC) < NF / 2);
      cmp("frame_strobe", "R4", frame_strobe_o, tick_en && (pos % FC) == 0);
      cmp("mframe_strobe", "R5", mframe_strobe_o, tick_en && pos == 0);
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R9: reset state, strobes follow tick_en
    tag = "R9";
    @(posedge clk); #1;
    chk_en = 1'b1;
    step(2);
    tick_en = 1'b0; step(2); tick_en = 1'b1;
    step(2);
    rst_n = 1'b1;

    // R1 R2 R7: free-running master, partner toggling is ignored
    tag = "R7";
    for (int i = 0; i < 3 * PER; i++) begin
      partner_mf_in = ((i / 7) % 2) == 1;
      step(1);
    end
    partner_mf_in = 1'b0;

    // R3: sparse ticks in master mode
    tag = "R3";
    for (int i = 0; i < 4 * PER; i++) begin
      tick_en = (i % 3) != 0;
      step(1);
    end
    tick_en = 1'b1;

    // R6 R8: slave realign from every position of the multiframe
    tag = "R6/R8";
    slave_mode = 1'b1;
    step(8);
    for (int off = 0; off < PER; off++) begin
      step(off);
      partner_mf_in = 1'b1;
      step(5);
      partner_mf_in = 1'b0;
      step(3);
    end
    // R8: partner phase locked to own wave, so edges land on the start
    for (int i = 0; i < 3 * PER; i++) begin
      partner_mf_in = mframe_sync_o;
      step(1);
    end
    partner_mf_in = 1'b0;

    // R3 R6: held detection released on the next tick
    tag = "R3/R6";
    for (int off = 0; off < PER / 2; off++) begin
      for (int i = 0; i < off + 12; i++) begin
        tick_en = (i % 2) == 0;
        partner_mf_in = (i >= off) && (i < off + 6);
        step(1);
      end
    end
    tick_en = 1'b1;
    partner_mf_in = 1'b0;
    step(PER);

    chk_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule